// File: doc/BRIEF.md
# Tachometer Period Discriminator with Lock Flag

This block judges the rotation speed of a motor from its tachometer pulse train. A free-running prescaler turns the system clock into a reference tick, one tick for every sixteen clocks by default. The block counts those ticks across one full tachometer period. It compares the count with a target of 512 ticks or 1024 ticks, chosen by a select pin. The regulated tachometer frequency is therefore the clock frequency divided by sixteen times the target.

Measurement alternates with rest. The first tachometer rising edge opens a measurement, and the next rising edge closes it and yields a verdict. The period after that is not measured, and the edge that follows opens the next measurement. A verdict is therefore produced once every two tachometer periods.

Each verdict sets two flags. The speed-up flag asks for more drive when the period was too long. The active-low lock flag is low when the period lies within one sixteenth of the target. A one-cycle strobe marks each new verdict.

Top module: `fg_speed_judge`

## Requirements
- R1: After reset, lock_n is 1, spd_up is 1 and meas_valid is 0, and they stay so until the first verdict.
- R2: The reference tick repeats every PRESCALE clocks (16 by default). A tachometer period of PRESCALE×K clocks measures as exactly K ticks.
- R3: n_sel = 1 selects a 512-tick target. n_sel = 0 selects a 1024-tick target.
- R4: Rising edges alternate between opening and closing a measurement, starting with opening after reset. An opening edge never produces a verdict, and the period between a closing edge and the next opening edge is not measured.
- R5: meas_valid is a single-cycle pulse. It is high in the third clock after the closing rising edge is applied at fg_in (two synchronizer flops, then the output register).
- R6: spd_up is 1 when the measured count is above the target. It is 0 when the count is at or below the target.
- R7: The tick count saturates at twice the target. A period longer than that reads as twice the target, which gives spd_up = 1 and lock_n = 1.
- R8: lock_n is 0 when the count lies within target ± target/16, inclusive. That is 480..544 ticks for the 512 target and 960..1088 ticks for the 1024 target. Otherwise lock_n is 1.
- R9: n_sel is sampled at the opening edge. A change during a measurement applies only from the next opening edge.
- R10: spd_up and lock_n change only together with meas_valid, and they hold between verdicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the source of the reference tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| fg_in | input | 1 | Tachometer pulse train, asynchronous |
| n_sel | input | 1 | Target select: 1 for 512 ticks, 0 for 1024 ticks |
| spd_up | output | 1 | 1 means accelerate, 0 means decelerate |
| lock_n | output | 1 | Low while the last measured period was inside the lock window |
| meas_valid | output | 1 | One-cycle pulse marking a new verdict |

## Verification
Directed periods placed exactly on and just beyond each lock limit, for both targets, separate an inclusive window from an exclusive one. They also show where the speed-up flag flips at the target itself. One instance keeps the default sixteen-clock prescaler, with periods that are whole multiples of sixteen clocks; this tells a correct tick count from one that is off by a tick. A second instance with a one-clock prescaler receives randomly chosen periods around both targets, overlong periods that exercise saturation, and a select change in mid-measurement. Short rest periods between measurements show that the unmeasured period leaves the flags alone.

// File: rtl/fgsj_pkg.sv
package fgsj_pkg;
   typedef enum logic {
      PH_REST  = 1'b0,
      PH_COUNT = 1'b1
   } phase_e;

   typedef struct packed {
      logic slow;
      logic lock_n;
   } verdict_t;
endpackage

// File: rtl/fgsj_tick_gen.sv
module fgsj_tick_gen #(
   parameter int DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_div
         localparam int W = $clog2(DIV);
         localparam logic [W-1:0] LAST = W'(DIV - 1);
         logic [W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (cnt == LAST)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end

         assign tick = (cnt == LAST);

         // R2: ticks are spaced by at least two clocks when dividing
         assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/fgsj_sync_edge.sv
module fgsj_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chain <= '0;
      else
         chain <= {chain[STAGES-1:0], din};
   end

   assign rise = chain[STAGES-1] & ~chain[STAGES];

   // R4: an edge pulse never lasts two cycles
   assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/fgsj_period_meter.sv
module fgsj_period_meter
   import fgsj_pkg::*;
#(
   parameter int TGT_FAST = 512,
   parameter int TGT_SLOW = 1024,
   parameter int CNT_W    = $clog2(2 * TGT_SLOW + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   input  logic             tick,
   input  logic             n_sel,
   output logic             done,
   output logic [CNT_W-1:0] count_eff,
   output logic             n_used
);
   localparam logic [CNT_W-1:0] CAP_FAST = CNT_W'(2 * TGT_FAST);
   localparam logic [CNT_W-1:0] CAP_SLOW = CNT_W'(2 * TGT_SLOW);

   phase_e           phase;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cap;
   logic             room;

   assign cap  = n_used ? CAP_FAST : CAP_SLOW;
   assign room = tick && (cnt < cap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_REST;
         cnt    <= '0;
         n_used <= 1'b1;
      end else if (rise) begin
         if (phase == PH_REST) begin
            phase  <= PH_COUNT;
            cnt    <= '0;
            n_used <= n_sel;
         end else begin
            phase  <= PH_REST;
         end
      end else if (phase == PH_COUNT && room) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign done      = rise && (phase == PH_COUNT);
   assign count_eff = (phase == PH_COUNT && room) ? cnt + 1'b1 : cnt;

   // R7: the count never passes its ceiling
   assert_cnt_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= cap);
   // R4: the count is frozen during the rest period
   assert_rest_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_REST && !rise) |=> $stable(cnt));
   // R9: the latched select moves only at an opening edge
   assert_sel_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise && phase == PH_REST) |=> $stable(n_used));
endmodule

// File: rtl/fgsj_verdict.sv
module fgsj_verdict
   import fgsj_pkg::*;
#(
   parameter int TGT_FAST = 512,
   parameter int TGT_SLOW = 1024,
   parameter int LOCK_SH  = 4,
   parameter int CNT_W    = $clog2(2 * TGT_SLOW + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic [CNT_W-1:0] count_eff,
   input  logic             n_used,
   output logic             spd_up,
   output logic             lock_n,
   output logic             valid
);
   localparam logic [CNT_W-1:0] T_F  = CNT_W'(TGT_FAST);
   localparam logic [CNT_W-1:0] T_S  = CNT_W'(TGT_SLOW);
   localparam logic [CNT_W-1:0] LO_F = CNT_W'(TGT_FAST - (TGT_FAST >> LOCK_SH));
   localparam logic [CNT_W-1:0] HI_F = CNT_W'(TGT_FAST + (TGT_FAST >> LOCK_SH));
   localparam logic [CNT_W-1:0] LO_S = CNT_W'(TGT_SLOW - (TGT_SLOW >> LOCK_SH));
   localparam logic [CNT_W-1:0] HI_S = CNT_W'(TGT_SLOW + (TGT_SLOW >> LOCK_SH));

   logic [CNT_W-1:0] tgt, lo, hi;
   verdict_t         nxt, cur;

   assign tgt = n_used ? T_F  : T_S;
   assign lo  = n_used ? LO_F : LO_S;
   assign hi  = n_used ? HI_F : HI_S;

   always_comb begin
      nxt.slow   = count_eff > tgt;
      nxt.lock_n = !((count_eff >= lo) && (count_eff <= hi));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur   <= '{slow: 1'b1, lock_n: 1'b1};
         valid <= 1'b0;
      end else begin
         valid <= done;
         if (done)
            cur <= nxt;
      end
   end

   assign spd_up = cur.slow;
   assign lock_n = cur.lock_n;

   // R5: the strobe is a single cycle
   assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
   // R10: the lock flag moves only with a verdict
   assert_lock_moves_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_n != $past(lock_n)) |-> valid);
   // R10: the speed flag moves only with a verdict
   assert_speed_moves_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (spd_up != $past(spd_up)) |-> valid);
   // R8: a locked verdict was taken with the count inside the window
   assert_lock_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && count_eff >= lo && count_eff <= hi) |=> !lock_n);
endmodule

// File: rtl/fg_speed_judge.sv
module fg_speed_judge #(
   parameter int PRESCALE    = 16,
   parameter int TGT_FAST    = 512,
   parameter int TGT_SLOW    = 1024,
   parameter int LOCK_SH     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fg_in,
   input  logic n_sel,
   output logic spd_up,
   output logic lock_n,
   output logic meas_valid
);
   localparam int CNT_W = $clog2(2 * TGT_SLOW + 1);

   generate
      if (PRESCALE < 1) begin : g_bad_prescale
         $error("PRESCALE must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (TGT_FAST >= TGT_SLOW) begin : g_bad_order
         $error("TGT_FAST must be below TGT_SLOW");
      end
      if ((TGT_FAST >> LOCK_SH) < 1) begin : g_bad_window
         $error("lock window rounds to zero");
      end
   endgenerate

   logic             tick, rise, done, n_used;
   logic [CNT_W-1:0] count_eff;

   fgsj_tick_gen #(.DIV(PRESCALE)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   fgsj_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (fg_in),
      .rise (rise)
   );

   fgsj_period_meter #(
      .TGT_FAST(TGT_FAST), .TGT_SLOW(TGT_SLOW), .CNT_W(CNT_W)
   ) u_meter (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise     (rise),
      .tick     (tick),
      .n_sel    (n_sel),
      .done     (done),
      .count_eff(count_eff),
      .n_used   (n_used)
   );

   fgsj_verdict #(
      .TGT_FAST(TGT_FAST), .TGT_SLOW(TGT_SLOW),
      .LOCK_SH(LOCK_SH), .CNT_W(CNT_W)
   ) u_verdict (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (done),
      .count_eff(count_eff),
      .n_used   (n_used),
      .spd_up   (spd_up),
      .lock_n   (lock_n),
      .valid    (meas_valid)
   );
endmodule

// File: tb/sim_fg_speed_judge.sv
`timescale 1ns/1ps
module sim_fg_speed_judge;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fg0 = 1'b0, n0 = 1'b1;
   logic fg1 = 1'b0, n1 = 1'b1;
   logic up0, ln0, v0, up1, ln1, v1;
   int   checks = 0;
   int   errors = 0;

   always #4 clk = ~clk;

   fg_speed_judge u0 (
      .clk(clk), .rst_n(rst_n), .fg_in(fg0), .n_sel(n0),
      .spd_up(up0), .lock_n(ln0), .meas_valid(v0));

   fg_speed_judge #(.PRESCALE(1)) u1 (
      .clk(clk), .rst_n(rst_n), .fg_in(fg1), .n_sel(n1),
      .spd_up(up1), .lock_n(ln1), .meas_valid(v1));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_fg(input int sel, input logic v);
      if (sel == 0) fg0 = v; else fg1 = v;
   endtask

   task automatic set_n(input int sel, input logic v);
      if (sel == 0) n0 = v; else n1 = v;
   endtask

   function automatic logic get_v(input int sel);
      return (sel == 0) ? v0 : v1;
   endfunction
   function automatic logic get_up(input int sel);
      return (sel == 0) ? up0 : up1;
   endfunction
   function automatic logic get_ln(input int sel);
      return (sel == 0) ? ln0 : ln1;
   endfunction

   // expected flags from the requirements (R3, R6, R7, R8)
   function automatic void judge(input int ticks, input bit nsel,
                                 output bit slow, output bit lkn);
      int t, c;
      t = nsel ? 512 : 1024;
      c = (ticks > 2 * t) ? 2 * t : ticks;
      slow = c > t;
      lkn  = !((c >= t - t / 16) && (c <= t + t / 16));
   endfunction

   // one measurement: opening edge, period iv clocks, closing edge, rest
   task automatic measure(input int sel, input int iv, input int ticks,
                          input bit n_open, input bit chg, input int rest,
                          input string tag);
      bit es, el;
      set_n(sel, n_open);
      set_fg(sel, 1'b1);
      step(2);
      set_fg(sel, 1'b0);
      step(1);
      // R4: the opening edge gives no verdict
      chk(get_v(sel) == 1'b0, {tag, " R4 open"}, get_v(sel), 0);
      if (chg) set_n(sel, !n_open);  // R9: change after the sample point
      step(iv - 3);
      set_fg(sel, 1'b1);
      step(1);
      chk(get_v(sel) == 1'b0, {tag, " R5 early"}, get_v(sel), 0);
      step(1);
      set_fg(sel, 1'b0);
      chk(get_v(sel) == 1'b0, {tag, " R5 early"}, get_v(sel), 0);
      step(1);
      chk(get_v(sel) == 1'b1, {tag, " R5 strobe"}, get_v(sel), 1);
      judge(ticks, n_open, es, el);
      chk(get_up(sel) == es, {tag, " R6 spd_up"}, get_up(sel), es);
      chk(get_ln(sel) == el, {tag, " R8 lock_n"}, get_ln(sel), el);
      step(1);
      chk(get_v(sel) == 1'b0, {tag, " R5 width"}, get_v(sel), 0);
      step(rest);
      // R10: flags hold through the rest period
      chk(get_up(sel) == es && get_ln(sel) == el, {tag, " R10 hold"},
          {get_up(sel), get_ln(sel)}, {es, el});
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd2718));
      step(3);
      // R1: reset state
      chk(ln0 == 1'b1 && up0 == 1'b1 && v0 == 1'b0, "R1 reset u0",
          {ln0, up0, v0}, 3'b110);
      rst_n = 1'b1;
      step(5);
      chk(ln1 == 1'b1 && up1 == 1'b1 && v1 == 1'b0, "R1 after release u1",
          {ln1, up1, v1}, 3'b110);

      // R2 R3: sixteen-clock tick, directed limits
      measure(0, 16 * 512,  512,  1'b1, 1'b0, 6, "R2 u0 512 on target");
      measure(0, 16 * 479,  479,  1'b1, 1'b0, 6, "R2 u0 479 below window");
      measure(0, 16 * 1088, 1088, 1'b0, 1'b0, 6, "R3 u0 1088 top edge");
      measure(0, 16 * 1089, 1089, 1'b0, 1'b0, 6, "R3 u0 1089 past edge");

      // R8: window limits on the one-clock instance
      measure(1, 480,  480,  1'b1, 1'b0, 4, "R8 480");
      measure(1, 544,  544,  1'b1, 1'b0, 4, "R8 544");
      measure(1, 545,  545,  1'b1, 1'b0, 4, "R8 545");
      measure(1, 959,  959,  1'b0, 1'b0, 4, "R8 959");
      measure(1, 960,  960,  1'b0, 1'b0, 4, "R8 960");
      measure(1, 1025, 1025, 1'b0, 1'b0, 4, "R6 1025");
      // R7: saturation
      measure(1, 3000, 3000, 1'b1, 1'b0, 4, "R7 sat 512");
      measure(1, 2600, 2600, 1'b0, 1'b0, 4, "R7 sat 1024");
      // R9: select change in mid-measurement applies next time
      measure(1, 1024, 1024, 1'b1, 1'b1, 4, "R9 mid change");
      chk(n1 == 1'b0, "R9 stimulus", n1, 0);
      measure(1, 1024, 1024, 1'b0, 1'b0, 4, "R9 next window");

      // R4: a long rest period is not measured
      measure(1, 1000, 1000, 1'b0, 1'b0, 3000, "R4 long rest");

      // random periods around both targets
      for (int i = 0; i < 40; i++) begin
         bit ns;
         int t, iv;
         ns = $urandom_range(0, 1) == 1;
         t  = ns ? 512 : 1024;
         if ($urandom_range(0, 9) == 0)
            iv = $urandom_range(2 * t - 4, 2 * t + 200);
         else
            iv = $urandom_range(t - t / 8, t + t / 8);
         measure(1, iv, iv, ns, 1'b0, $urandom_range(2, 40), "R6 random");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule